// File: doc/BRIEF.md
# Bitwise Bus Arbitration Monitor

This block sits beside the transmitter of a node on a single-wire, wired-AND bus, where logic 0 is the dominant level and logic 1 is recessive. While the node sends a frame, it compares, at every bit strobe, the bit the node wants to send with the bit it reads back from the bus. As long as the two agree, the node keeps its transmit permit. The first disagreement anywhere in the frame, from its first bit to its last, counts as a lost arbitration. The block then raises a lost flag, withdraws the permit and forces the line driver to the recessive level. For the rest of that frame the node only receives.

After a loss the node stays locked out. Requests to start a frame are ignored until the inter-frame-space detector reports a gap on the bus. The lost flag stays set until the node next starts a frame that is accepted. By default any disagreement counts as a loss. A parameter can narrow this to the classic case only: the node sends recessive and reads dominant.

Top module: `arb_monitor`

## Requirements
- R1: After reset, `txPermit` is 0, `arbLost` is 0 and `driveBit` is 1 (recessive).
- R2: When the monitor is idle, `frameStart` at a clock edge sets `txPermit` to 1 and `arbLost` to 0 after that edge.
- R3: `driveBit` equals `txBit` while `txPermit` is 1 and is 1 (recessive, never dominant 0) while `txPermit` is 0.
- R4: A `bitStrobe` cycle while permitted in which `txBit` equals `rxBit` leaves `txPermit` at 1 and `arbLost` at 0.
- R5: A `bitStrobe` cycle while permitted in which `txBit` differs from `rxBit` sets `arbLost` to 1 and `txPermit` to 0 after that edge. With the default `ANY_MISMATCH`=1, both directions count: sent 1 and read 0, or sent 0 and read 1.
- R6: A mismatch between `txBit` and `rxBit` has no effect when `bitStrobe` is 0 or when `txPermit` is 0.
- R7: After a loss, `frameStart` is ignored: `txPermit` stays 0 and `arbLost` stays 1 until `ifsDetect` is seen.
- R8: `ifsDetect` ends any frame: `txPermit` goes to 0 after the edge. `arbLost` keeps its value until the next accepted `frameStart`.
- R9: `ifsDetect` and `frameStart` in the same cycle start a new frame (`txPermit` 1, `arbLost` 0), even right after a loss. A `bitStrobe` in an `ifsDetect` cycle is not compared.
- R10: `frameStart` while a frame is being sent is ignored. The frame goes on and `arbLost` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitStrobe | input | 1 | One-cycle pulse at the bit sampling point |
| txBit | input | 1 | Bit the node wants to transmit |
| rxBit | input | 1 | Bit read back from the bus |
| frameStart | input | 1 | Node requests to begin a frame |
| ifsDetect | input | 1 | Inter-frame space detected on the bus |
| txPermit | output | 1 | Node may drive the bus |
| arbLost | output | 1 | Arbitration was lost in the last frame |
| driveBit | output | 1 | Level handed to the line driver |

## Verification
The bench goes after a loss in a late bit of a long frame. A design that checked only a leading field would keep transmitting there. It also sends dominant while reading recessive, which a design that knows only one mismatch direction would miss. It drives mismatches with no strobe and while not permitted, where a design that compares too eagerly would flag a loss it never had. It repeats `frameStart` during a lockout and during a frame in progress, where a design that restarts too readily would drive the bus early or clear the flag. It also puts `ifsDetect` in the same cycle as a start request or a strobe, where wrong priority shows up as a lost or spurious frame.

// File: rtl/arb_monitor_pkg.sv
package arb_monitor_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_SEND = 2'd1,
    ARB_LOCK = 2'd2
  } arbState_t;

  typedef struct packed {
    logic permit;
    logic setLost;
    logic clearLost;
  } arbCtrl_t;

endpackage

// File: rtl/arb_monitor_dp.sv
module arb_monitor_dp
  import arb_monitor_pkg::*;
#(
  parameter bit ANY_MISMATCH = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bitStrobe,
  input  logic     txBit,
  input  logic     rxBit,
  input  arbCtrl_t ctrl,
  output logic     bitClash,
  output logic     lostFlag,
  output logic     driveBit
);

  logic disagree;

  generate
    if (ANY_MISMATCH) begin : gAnyDir
      assign disagree = txBit ^ rxBit;
    end else begin : gRecessiveOnly
      assign disagree = txBit & ~rxBit;
    end
  endgenerate

  assign bitClash = bitStrobe & disagree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lostFlag <= 1'b0;
    end else if (ctrl.clearLost) begin
      lostFlag <= 1'b0;
    end else if (ctrl.setLost) begin
      lostFlag <= 1'b1;
    end
  end

  assign driveBit = ctrl.permit ? txBit : 1'b1;

endmodule

// File: rtl/arb_monitor_ctrl.sv
module arb_monitor_ctrl
  import arb_monitor_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      ifsDetect,
  input  logic      bitClash,
  output arbCtrl_t  ctrl,
  output arbState_t state
);

  arbState_t nextState;
  logic      acceptStart;

  assign acceptStart = frameStart & (ifsDetect | (state == ARB_IDLE));

  always_comb begin
    nextState = state;
    if (ifsDetect) begin
      nextState = frameStart ? ARB_SEND : ARB_IDLE;
    end else begin
      unique case (state)
        ARB_IDLE: if (frameStart) nextState = ARB_SEND;
        ARB_SEND: if (bitClash) nextState = ARB_LOCK;
        ARB_LOCK: nextState = ARB_LOCK;
        default:  nextState = ARB_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ARB_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    ctrl.permit    = (state == ARB_SEND);
    ctrl.setLost   = (state == ARB_SEND) & bitClash & ~ifsDetect;
    ctrl.clearLost = acceptStart;
  end

endmodule

// File: rtl/arb_monitor.sv
module arb_monitor
  import arb_monitor_pkg::*;
#(
  parameter bit ANY_MISMATCH = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitStrobe,
  input  logic txBit,
  input  logic rxBit,
  input  logic frameStart,
  input  logic ifsDetect,
  output logic txPermit,
  output logic arbLost,
  output logic driveBit
);

  arbCtrl_t  ctrl;
  arbState_t ctrlState;
  logic      bitClash;

  arb_monitor_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .ifsDetect  (ifsDetect),
    .bitClash   (bitClash),
    .ctrl       (ctrl),
    .state      (ctrlState)
  );

  arb_monitor_dp #(.ANY_MISMATCH(ANY_MISMATCH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bitStrobe (bitStrobe),
    .txBit     (txBit),
    .rxBit     (rxBit),
    .ctrl      (ctrl),
    .bitClash  (bitClash),
    .lostFlag  (arbLost),
    .driveBit  (driveBit)
  );

  assign txPermit = ctrl.permit;

endmodule

// File: rtl/arb_monitor_checker.sv
module arb_monitor_checker
  import arb_monitor_pkg::*;
#(
  parameter bit ANY_MISMATCH = 1'b1
) (
  input logic      clk,
  input logic      rstN,
  input logic      bitStrobe,
  input logic      txBit,
  input logic      rxBit,
  input logic      frameStart,
  input logic      ifsDetect,
  input logic      txPermit,
  input logic      arbLost,
  input logic      driveBit,
  input arbState_t ctrlState
);

  logic lossBit;
  assign lossBit = ANY_MISMATCH ? (txBit != rxBit) : (txBit && !rxBit);

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ARB_IDLE && frameStart) |=> (txPermit && !arbLost)); // R2

  AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState != ARB_SEND) |-> driveBit); // R3

  AST_MATCH_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (txPermit && bitStrobe && txBit == rxBit && !ifsDetect) |=> (txPermit && !arbLost)); // R4

  AST_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (txPermit && bitStrobe && lossBit && !ifsDetect) |=> (!txPermit && arbLost)); // R5

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ARB_LOCK && !ifsDetect) |=> (ctrlState == ARB_LOCK && !txPermit && arbLost)); // R7

  AST_LOST_CLEARS_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(arbLost) |-> txPermit); // R8

  AST_IFS_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    (ifsDetect && frameStart) |=> (txPermit && !arbLost)); // R9

endmodule

bind arb_monitor arb_monitor_checker #(.ANY_MISMATCH(ANY_MISMATCH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitStrobe  (bitStrobe),
  .txBit      (txBit),
  .rxBit      (rxBit),
  .frameStart (frameStart),
  .ifsDetect  (ifsDetect),
  .txPermit   (txPermit),
  .arbLost    (arbLost),
  .driveBit   (driveBit),
  .ctrlState  (ctrlState)
);

// File: tb/arb_monitor_test.sv
module arb_monitor_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStrobe = 1'b0, txBit = 1'b1, rxBit = 1'b1;
  logic frameStart = 1'b0, ifsDetect = 1'b0;
  logic txPermit, arbLost, driveBit;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model: 0 idle, 1 sending, 2 locked
  int mState = 0;
  bit mLost = 1'b0;

  always #10 clk = ~clk;

  arb_monitor uut (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .txBit(txBit), .rxBit(rxBit),
    .frameStart(frameStart), .ifsDetect(ifsDetect),
    .txPermit(txPermit), .arbLost(arbLost), .driveBit(driveBit)
  );

  function automatic int nextModelState(int s, bit fs, bit ifs, bit stb, bit tb, bit rb);
    if (ifs) return fs ? 1 : 0;
    if (s == 0 && fs) return 1;
    if (s == 1 && stb && (tb != rb)) return 2;
    return s;
  endfunction

  function automatic bit nextModelLost(int s, bit l, bit fs, bit ifs, bit stb, bit tb, bit rb);
    if (fs && (ifs || s == 0)) return 1'b0;
    if (s == 1 && !ifs && stb && (tb != rb)) return 1'b1;
    return l;
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // apply inputs, clock once, compare outputs against model
  task automatic step(string req, bit fs, bit ifs, bit stb, bit tb, bit rb);
    int ns;
    bit nl;
    @(negedge clk);
    frameStart = fs; ifsDetect = ifs; bitStrobe = stb; txBit = tb; rxBit = rb;
    ns = nextModelState(mState, fs, ifs, stb, tb, rb);
    nl = nextModelLost(mState, mLost, fs, ifs, stb, tb, rb);
    @(posedge clk);
    #2;
    mState = ns;
    mLost = nl;
    check(req, "txPermit", txPermit, (mState == 1));
    check(req, "arbLost", arbLost, mLost);
    check("R3", "driveBit", driveBit, (mState == 1) ? tb : 1'b1);
  endtask

  task automatic idleCycle(string req);
    step(req, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #5_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1d5a_0c37;
    void'($urandom(seed));

    #25;
    check("R1", "txPermit", txPermit, 1'b0);
    check("R1", "arbLost", arbLost, 1'b0);
    check("R1", "driveBit", driveBit, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    idleCycle("R1");

    // R6: strobe with mismatch while idle does nothing
    step("R6", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R2: start a frame
    step("R2", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R10: start again while sending is ignored
    step("R10", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R4: long run of matching bits
    for (int i = 0; i < 40; i++) step("R4", 1'b0, 1'b0, 1'b1, i[0], i[0]);
    // R6: mismatch without strobe
    step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R5: late loss, recessive sent, dominant read
    step("R5", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    // R7: start requests ignored while locked, strobes too
    step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    // R8: ifs unlocks but lost stays
    step("R8", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    idleCycle("R8");
    // R2: new frame clears lost
    step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5: dominant sent, recessive read also loses
    step("R5", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    // R9: ifs and start together right after loss
    step("R9", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    // R9: strobe with mismatch during ifs is not compared
    step("R9", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R9", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R8: ifs while sending ends frame, lost stays 0
    step("R8", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // random phase: mostly wired-AND bus with occasional faults
    for (int i = 0; i < 4000; i++) begin
      bit fs, ifs, stb, tb, other, rb;
      fs = ($urandom % 16) == 0;
      ifs = ($urandom % 40) == 0;
      stb = ($urandom % 3) == 0;
      tb = $urandom % 2;
      other = ($urandom % 12) != 0;
      rb = (($urandom % 50) == 0) ? ~tb : (tb & other);
      step("R5", fs, ifs, stb, tb, rb);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule